// File: doc/BRIEF.md
# Legacy Serial Audio Reformatter

This block takes the three-wire sample stream of an early digital-audio front end and turns it into a standard two-channel I2S stream. The input has a bit clock, a word clock and a data line. A frame is about 49 bit-clock periods long, which is not a power of two. Each sample is a 16-bit two's complement word sent most significant bit first. All three input wires are asynchronous to the block. They are oversampled in one fast system clock domain, and their edges are found there.

Each word is captured at the word-clock transition that closes it. Words are then paired as left and right. One pending pair is held for the output framer. The framer regenerates a 32Fs bit clock by dividing the system clock, and drives a matching word select. When a new output frame starts and no new pair has arrived, the previous pair is sent again and an underflow flag pulses. The output is a free-running serial line. It has no valid/ready handshake and cannot apply back-pressure: if a second pair completes before the first has been sent, the newer pair replaces the older one.

Top module: `legacy_pcm_reframer`

## Requirements
- R1: `in_bck`, `in_wck` and `in_dat` each pass through SYNC_STAGES flops on `clk` before use. Data is sampled on a rising edge of the synchronised bit clock. The system clock must run at least 8 times the input bit clock.
- R2: A word is taken at each transition of the word clock. It consists of the last WORD_W data samples taken before that transition, first sample as MSB. Any extra bit periods in the roughly 49-period frame have no effect on the captured value.
- R3: A word closed while the word clock was high (a falling transition) is the left channel. A word closed while it was low (a rising transition) is the right channel. A left word followed by a right word forms one pair.
- R4: A word is discarded if fewer than WORD_W rising bit-clock edges were seen since the previous word-clock transition or since reset. A right word with no valid left word before it is also discarded.
- R5: Each output frame lasts 2*WORD_W bit periods. `out_ws` is 0 during the left half and 1 during the right half. The MSB of each word appears one bit period after the `out_ws` transition. The right LSB occupies the first bit period of the next frame.
- R6: `out_sd` and `out_ws` change only in the cycle where `out_bck` falls.
- R7: The period of `out_bck` is 2*OUT_HALF system clocks. It is low for the first OUT_HALF clocks and high for the second OUT_HALF clocks.
- R8: A pair is moved to the output only at a frame start, which is the cycle where `out_ws` falls. If no new pair has arrived since the last move, the previous pair is repeated and `underflow` is high for exactly that one cycle.
- R9: After reset, `out_sd` stays 0 until a complete pair has been captured.
- R10: During reset, `out_bck` = 0, `out_ws` = 1, `out_sd` = 0 and `underflow` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_bck | input | 1 | Legacy bit clock, asynchronous |
| in_wck | input | 1 | Legacy word clock, high while the left word is shifted, asynchronous |
| in_dat | input | 1 | Legacy serial data, changes on the falling edge of the bit clock |
| out_bck | output | 1 | Regenerated I2S bit clock |
| out_ws | output | 1 | I2S word select, 0 for left and 1 for right |
| out_sd | output | 1 | I2S serial data, MSB first |
| underflow | output | 1 | One-cycle pulse when a frame repeats the previous pair |

## Verification
The stimulus mixes several kinds of sample values:
- Full-scale positive and negative values and values one step from zero. These show whether the MSB is placed correctly and whether the sign is preserved.
- Mirrored left/right values. These show whether the two channels are swapped.

Padding bits are driven as all ones in some frames and all zeros in others, so a capture window that slips onto the wrong 16 bits changes the result. A truncated word sent right after reset checks that partial words and orphan right words never reach the output. An idle gap in the middle of the stream forces repeated frames. This separates a correct repeat with an underflow pulse from stale, skipped or duplicated pairs.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
  // Width of the bundle of legacy input wires passed through the synchroniser.
  localparam int unsigned LPR_IN_WIRES = 3;

  // Channel owning a word, named after the word-clock level while it shifted.
  typedef enum logic {
    CH_RIGHT = 1'b0,
    CH_LEFT  = 1'b1
  } lpr_chan_e;
endpackage

// File: rtl/lpr_sync.sv
module lpr_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // Flop chain; stage 0 is the metastable capture flop.
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/lpr_capture.sv
module lpr_capture
  import lpr_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bck_s,
  input  logic                  wck_s,
  input  logic                  dat_s,
  output logic                  pair_stb,
  output logic [2*WORD_W-1:0]   pair_data
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);

  logic              primed_q;
  logic              bck_q;
  logic              wck_q;
  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  bits_q;
  logic              have_left_q;
  logic [WORD_W-1:0] left_q;

  logic      bck_rise;
  logic      wck_edge;
  logic      word_full;
  lpr_chan_e closing_chan;

  // Edges are only trusted once the previous-value flops hold real samples.
  assign bck_rise     = primed_q & bck_s & ~bck_q;
  assign wck_edge     = primed_q & (wck_s ^ wck_q);
  assign word_full    = (bits_q == CNT_W'(WORD_W));
  assign closing_chan = lpr_chan_e'(wck_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed_q    <= 1'b0;
      bck_q       <= 1'b0;
      wck_q       <= 1'b0;
      shift_q     <= '0;
      bits_q      <= '0;
      have_left_q <= 1'b0;
      left_q      <= '0;
      pair_stb    <= 1'b0;
      pair_data   <= '0;
    end else begin
      primed_q <= 1'b1;
      bck_q    <= bck_s;
      wck_q    <= wck_s;
      pair_stb <= 1'b0;

      // Keep only the newest WORD_W samples; older padding falls off the top.
      if (bck_rise) shift_q <= {shift_q[WORD_W-2:0], dat_s};

      if (wck_edge) begin
        bits_q <= '0;
        if (closing_chan == CH_LEFT) begin
          left_q      <= shift_q;
          have_left_q <= word_full;
        end else begin
          if (word_full && have_left_q) begin
            pair_data <= {left_q, shift_q};
            pair_stb  <= 1'b1;
          end
          have_left_q <= 1'b0;
        end
      end else if (bck_rise && !word_full) begin
        bits_q <= bits_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lpr_i2s_tx.sv
module lpr_i2s_tx #(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned OUT_HALF = 44
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pair_stb,
  input  logic [2*WORD_W-1:0] pair_data,
  output logic                out_bck,
  output logic                out_ws,
  output logic                out_sd,
  output logic                underflow
);
  localparam int unsigned SLOTS  = 2 * WORD_W;
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned PER    = 2 * OUT_HALF;
  localparam int unsigned DIV_W  = (PER > 1) ? $clog2(PER) : 1;

  logic [DIV_W-1:0]  div_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOTS-1:0]  pend_q;
  logic              fresh_q;
  logic [SLOTS-1:0]  word_q;
  logic [SLOTS-1:0]  ser_q;
  logic              sd_q;

  logic slot_end;
  logic frame_end;

  assign slot_end  = (div_q == DIV_W'(PER - 1));
  assign frame_end = slot_end && (slot_q == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q     <= '0;
      slot_q    <= SLOT_W'(SLOTS - 1);
      pend_q    <= '0;
      fresh_q   <= 1'b0;
      word_q    <= '0;
      ser_q     <= '0;
      sd_q      <= 1'b0;
      underflow <= 1'b0;
    end else begin
      underflow <= 1'b0;
      div_q     <= slot_end ? '0 : div_q + 1'b1;

      if (pair_stb) pend_q <= pair_data;

      if (slot_end) begin
        if (frame_end) begin
          slot_q <= '0;
          // First slot of a frame still carries the LSB of the word just sent.
          sd_q   <= word_q[0];
          if (fresh_q) begin
            word_q <= pend_q;
            ser_q  <= pend_q;
          end else begin
            ser_q     <= word_q;
            underflow <= 1'b1;
          end
        end else begin
          slot_q <= slot_q + 1'b1;
          sd_q   <= ser_q[SLOTS-1];
          ser_q  <= {ser_q[SLOTS-2:0], 1'b0};
        end
      end

      if (pair_stb)       fresh_q <= 1'b1;
      else if (frame_end) fresh_q <= 1'b0;
    end
  end

  assign out_bck = (div_q >= DIV_W'(OUT_HALF));
  assign out_ws  = (slot_q >= SLOT_W'(WORD_W));
  assign out_sd  = sd_q;
endmodule

// File: rtl/legacy_pcm_reframer.sv
module legacy_pcm_reframer
  import lpr_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OUT_HALF    = 44
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_bck,
  input  logic in_wck,
  input  logic in_dat,
  output logic out_bck,
  output logic out_ws,
  output logic out_sd,
  output logic underflow
);
  localparam int unsigned PAIR_W = 2 * WORD_W;

  logic [LPR_IN_WIRES-1:0] raw_in;
  logic [LPR_IN_WIRES-1:0] sync_in;
  logic                    pair_stb;
  logic [PAIR_W-1:0]       pair_data;

  assign raw_in = {in_bck, in_wck, in_dat};

  lpr_sync #(
    .WIDTH  (LPR_IN_WIRES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sync_in)
  );

  lpr_capture #(
    .WORD_W (WORD_W)
  ) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .bck_s     (sync_in[2]),
    .wck_s     (sync_in[1]),
    .dat_s     (sync_in[0]),
    .pair_stb  (pair_stb),
    .pair_data (pair_data)
  );

  lpr_i2s_tx #(
    .WORD_W   (WORD_W),
    .OUT_HALF (OUT_HALF)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .pair_stb  (pair_stb),
    .pair_data (pair_data),
    .out_bck   (out_bck),
    .out_ws    (out_ws),
    .out_sd    (out_sd),
    .underflow (underflow)
  );
endmodule

// File: rtl/lpr_checks.sv
module lpr_checks #(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned OUT_HALF = 44
) (
  input logic clk,
  input logic rst_n,
  input logic out_bck,
  input logic out_ws,
  input logic out_sd,
  input logic underflow,
  input logic pair_stb
);
  localparam int unsigned SLOTS = 2 * WORD_W;
  localparam int unsigned PER   = 2 * OUT_HALF;

  logic        bck_p_q;
  logic        ws_p_q;
  logic        rise_seen_q;
  logic        frame_seen_q;
  logic        pair_seen_q;
  int unsigned since_rise_q;
  int unsigned falls_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bck_p_q      <= 1'b0;
      ws_p_q       <= 1'b1;
      rise_seen_q  <= 1'b0;
      frame_seen_q <= 1'b0;
      pair_seen_q  <= 1'b0;
      since_rise_q <= 0;
      falls_q      <= 0;
    end else begin
      bck_p_q <= out_bck;
      ws_p_q  <= out_ws;
      if (pair_stb) pair_seen_q <= 1'b1;
      if (out_bck && !bck_p_q) begin
        rise_seen_q  <= 1'b1;
        since_rise_q <= 1;
      end else begin
        since_rise_q <= since_rise_q + 1;
      end
      if (ws_p_q && !out_ws) begin
        frame_seen_q <= 1'b1;
        falls_q      <= 1;
      end else if (bck_p_q && !out_bck) begin
        falls_q <= falls_q + 1;
      end
    end
  end

  assert_ws_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_ws) |-> $fell(out_bck));

  assert_sd_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_sd) |-> $fell(out_bck));

  assert_bck_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_seen_q && out_bck && !bck_p_q) |-> (since_rise_q == PER));

  assert_frame_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_seen_q && ws_p_q && !out_ws) |-> (falls_q == SLOTS));

  assert_uf_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> !underflow);

  assert_uf_at_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $fell(out_ws));

  assert_zero_before_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_seen_q |-> !out_sd);
endmodule

bind legacy_pcm_reframer lpr_checks #(
  .WORD_W   (WORD_W),
  .OUT_HALF (OUT_HALF)
) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_bck   (out_bck),
  .out_ws    (out_ws),
  .out_sd    (out_sd),
  .underflow (underflow),
  .pair_stb  (pair_stb)
);

// File: tb/tb_legacy_pcm_reframer.sv
`timescale 1ns/1ps
module tb_legacy_pcm_reframer;
  localparam int OUT_HALF = 6;
  localparam int IN_HALF  = 4;
  localparam int NPAIRS   = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic in_bck, in_wck, in_dat;
  logic out_bck, out_ws, out_sd, underflow;

  always #4 clk = ~clk;

  legacy_pcm_reframer #(.WORD_W(16), .SYNC_STAGES(2), .OUT_HALF(OUT_HALF)) dut (
    .clk(clk), .rst_n(rst_n), .in_bck(in_bck), .in_wck(in_wck), .in_dat(in_dat),
    .out_bck(out_bck), .out_ws(out_ws), .out_sd(out_sd), .underflow(underflow));

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  logic [31:0] pairs [NPAIRS];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // R1: inputs change on negedge clk, asynchronous to the design's view of them.
  task automatic drive_bit(input logic d, input logic w);
    @(negedge clk);
    in_bck = 1'b0; in_dat = d; in_wck = w;
    repeat (IN_HALF - 1) @(negedge clk);
    @(negedge clk);
    in_bck = 1'b1;
    repeat (IN_HALF - 1) @(negedge clk);
  endtask

  // 49 bit periods: 24 with word clock high, 25 with it low; padding first.
  task automatic send_frame(input logic [15:0] l, input logic [15:0] r, input logic pad);
    exp_q.push_back({l, r});
    for (int i = 0; i < 24; i++) drive_bit((i < 8) ? pad : l[15 - (i - 8)], 1'b1);
    for (int i = 0; i < 25; i++) drive_bit((i < 9) ? pad : r[15 - (i - 9)], 1'b0);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_bck = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  // Scoreboard monitor: decodes I2S frames and compares with the queue.
  logic        mb_prev, ws_smp, sd_rise, rise_seen, per_bad, stab_bad, uf_pend, flag_prev;
  int          cyc_since, frames, nuf, ndata;
  logic [31:0] sr, prev_exp, expv;

  always @(negedge clk) begin
    if (!rst_n) begin
      mb_prev = 0; ws_smp = 0; sd_rise = 0; rise_seen = 0; per_bad = 0; stab_bad = 0;
      uf_pend = 0; flag_prev = 0; cyc_since = 0; frames = 0; nuf = 0; ndata = 0;
      sr = '0; prev_exp = '0;
    end else begin
      if (underflow) uf_pend = 1;
      if (out_bck && !mb_prev) begin
        if (rise_seen && cyc_since != 2 * OUT_HALF) per_bad = 1;
        rise_seen = 1; cyc_since = 0; sd_rise = out_sd;
        sr = {sr[30:0], out_sd};
        if (!out_ws && ws_smp) begin
          if (frames == 1) chk(flag_prev, "R9 first frame is a zero underflow frame", 32'(flag_prev), 32'd1);
          if (frames > 0) begin
            if (flag_prev) begin
              expv = prev_exp; nuf++;
            end else if (exp_q.size() == 0) begin
              expv = prev_exp;
              chk(1'b0, "R8 new pair emitted with none pending", sr, prev_exp);
            end else begin
              expv = exp_q.pop_front(); ndata++;
            end
            chk(sr == expv, "R2 R3 R4 R5 frame content", sr, expv);
            chk(!per_bad, "R7 bit clock period", 32'(per_bad), 32'd0);
            chk(!stab_bad, "R6 data stable while bit clock high", 32'(stab_bad), 32'd0);
            per_bad = 0; stab_bad = 0;
            prev_exp = expv;
          end
          frames++;
          flag_prev = uf_pend; uf_pend = 0;
        end
        ws_smp = out_ws;
      end else if (out_bck && out_sd != sd_rise) begin
        stab_bad = 1;
      end
      cyc_since++;
      mb_prev = out_bck;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    pairs[0]  = {16'h8000, 16'h7FFF};
    pairs[1]  = {16'hFFFF, 16'h0001};
    pairs[2]  = {16'h0000, 16'hFFFF};
    pairs[3]  = {16'hA5A5, 16'h5A5A};
    pairs[4]  = {16'h1234, 16'hFEDC};
    pairs[5]  = {16'h0001, 16'h8000};
    pairs[6]  = {16'h7FFF, 16'h8001};
    pairs[7]  = {16'hC3C3, 16'h3C3C};
    pairs[8]  = {16'hFFFE, 16'h0002};
    pairs[9]  = {16'h4000, 16'hBFFF};
    pairs[10] = {16'h0F0F, 16'hF0F0};
    pairs[11] = {16'h8421, 16'h1248};

    in_bck = 0; in_wck = 0; in_dat = 0; rst_n = 0;
    repeat (5) @(negedge clk);
    chk(out_bck == 0 && out_ws == 1 && out_sd == 0 && underflow == 0,
        "R10 reset state", {28'd0, out_bck, out_ws, out_sd, underflow}, 32'h4);
    rst_n = 1;

    idle(3 * 32 * 2 * OUT_HALF);

    // R4: truncated left word then an orphan right word; neither may appear.
    for (int i = 0; i < 10; i++) drive_bit(1'b1, 1'b1);
    for (int i = 0; i < 25; i++) drive_bit(i[0], 1'b0);

    for (int k = 0; k < NPAIRS; k++) begin
      send_frame(pairs[k][31:16], pairs[k][15:0], k[0]);
      if (k == 5) idle(700);   // R8: forces repeated frames mid-stream
    end
    for (int i = 0; i < 3; i++) drive_bit(1'b0, 1'b1);  // closes the last right word
    idle(6 * 32 * 2 * OUT_HALF);

    chk(exp_q.size() == 0, "R8 every pair delivered", 32'(exp_q.size()), 32'd0);
    chk(ndata == NPAIRS, "R8 each pair emitted once", 32'(ndata), 32'(NPAIRS));
    chk(nuf > 0, "R8 repeat frames observed", 32'(nuf), 32'd1);
    summary();
    $finish;
  end
endmodule